// File: doc/BRIEF.md
# Multiplexed pixel input pipeline

This block sits between a two-phase pixel port and a colour back end. The two-phase port carries an A half and a B half of every input bit. Each accepted input word holds both halves, with 8-bit red, green and blue fields, two palette-select bits, a blank bit and a sync bit per half. The block turns these words into a stream of one pixel per clock. In two-phase mode a word yields two pixels, A first and then B. In single-phase mode a word yields one pixel, taken from the A half, and the B half is discarded.

On the way through, each pixel is reformatted according to the selected colour format. Its select bits are compared with a programmed code to produce a per-pixel "selected" flag. Blanked pixels, and optionally unselected pixels, have their colour forced to zero. Sync is gated by an enable bit. An ungated copy of sync travels alongside the pixel, so it leaves the block delayed by exactly the pipeline.

Both stream edges use valid/ready. An input word moves on a clock edge where `in_valid` and `in_ready` are both high. An output pixel is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every output holds its value. In that case `in_ready` drops as soon as the captured word still has a phase waiting. `in_ready` depends combinationally on `out_ready`. Configuration inputs must stay stable while pixels are in flight. `CW` must be at least 8.

Top module: `pixin_pipe`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid` is 0 and `out_blank` is 1. `in_ready` is 1 after reset.
- R2: With `cfg_mux2`=1, each accepted word produces two output pixels, the A half first and then the B half.
- R3: With `cfg_mux2`=0, each accepted word produces one output pixel, built from the A half only. The B half has no effect on any output.
- R4: While `out_valid`=1 and `out_ready`=0, all outputs hold their values on the next cycle. No pixel is lost or duplicated under any back-pressure pattern.
- R5: In two-phase mode, with the output register full and stalled, `in_ready` is 0 while the B half of the captured word is still waiting.
- R6: `cfg_fmt`=0 (and the unused code 3) selects 24-bit colour: out_red/out_grn/out_blu equal the red/green/blue input fields.
- R7: `cfg_fmt`=1 selects 15-bit colour. The 16-bit word {green,blue} is taken, and bits 14:10, 9:5 and 4:0 go to red, green and blue. Each field is left-aligned with zero low bits.
- R8: `cfg_fmt`=2 selects 8-bit index mode: the red field appears on all three colour outputs.
- R9: `out_sel` is 1 exactly when the pixel's two select bits equal `cfg_sel_code`.
- R10: When `cfg_kill_unsel`=1 and `out_sel`=0, all colour outputs are zero.
- R11: `out_blank` equals the pixel's blank bit. When it is 1, all colour outputs are zero.
- R12: `out_sync` equals the pixel's sync bit AND `cfg_sync_en`.
- R13: `out_sync_dly` equals the pixel's sync bit ungated. It travels with its pixel, appearing two clock edges after the word is presented when there is no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mux2 | input | 1 | 1: two-phase (A then B), 0: single-phase (A only) |
| cfg_fmt | input | 2 | Colour format: 0 24-bit, 1 15-bit, 2 index, 3 as 0 |
| cfg_sel_code | input | 2 | Code the select bits must match |
| cfg_kill_unsel | input | 1 | Zero colour of unselected pixels |
| cfg_sync_en | input | 1 | Pass sync to `out_sync` |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted this edge when high with in_valid |
| in_red_a | input | CW | Red field, A half |
| in_grn_a | input | CW | Green field, A half |
| in_blu_a | input | CW | Blue field, A half |
| in_red_b | input | CW | Red field, B half |
| in_grn_b | input | CW | Green field, B half |
| in_blu_b | input | CW | Blue field, B half |
| in_psel_a | input | 2 | Select bits, A half |
| in_psel_b | input | 2 | Select bits, B half |
| in_blank_a | input | 1 | Blank, A half |
| in_blank_b | input | 1 | Blank, B half |
| in_sync_a | input | 1 | Sync, A half |
| in_sync_b | input | 1 | Sync, B half |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Back end accepts the pixel |
| out_red | output | CW | Red output |
| out_grn | output | CW | Green output |
| out_blu | output | CW | Blue output |
| out_sel | output | 1 | Pixel selected flag |
| out_blank | output | 1 | Blank of the pixel |
| out_sync | output | 1 | Gated sync |
| out_sync_dly | output | 1 | Ungated sync, delayed with the pixel |

## Verification
The bench builds the block with its default `CW`=8, so the 15-bit packing uses the full {green,blue} word. With two select bits there are only four codes, so every combination of mode, format, select code, kill bit and sync enable can be swept (96 configurations). Each configuration runs eight words whose select, blank and sync bits cycle through their values, with expected pixels computed arithmetically. An uneven ready pattern exercises stalls throughout. Directed runs pin down the exact output latency and the input stall in two-phase mode.

// File: rtl/pixin_pkg.sv
package pixin_pkg;

  typedef enum logic [1:0] {
    FMT_RGB24 = 2'd0,
    FMT_RGB15 = 2'd1,
    FMT_IDX8  = 2'd2
  } fmt_e;

  localparam int unsigned PS_W  = 2;
  localparam int unsigned F15_W = 5;

  typedef struct packed {
    logic [PS_W-1:0] ps;
    logic            blank;
    logic            sync;
  } pix_ctl_t;

endpackage

// File: rtl/pixin_capture.sv
module pixin_capture
  import pixin_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_mux2,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3*CW-1:0]   in_col_a,
  input  logic [3*CW-1:0]   in_col_b,
  input  pix_ctl_t          in_ctl_a,
  input  pix_ctl_t          in_ctl_b,
  input  logic              take,
  output logic              cur_valid,
  output logic [3*CW-1:0]   cur_col,
  output pix_ctl_t          cur_ctl
);

  logic [3*CW-1:0] col_a_q, col_b_q;
  pix_ctl_t        ctl_a_q, ctl_b_q;
  logic            full_q, ph_q;
  logic            last_ph, accept;

  assign last_ph  = !cfg_mux2 || ph_q;
  assign in_ready = !full_q || (take && last_ph);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q  <= 1'b0;
      ph_q    <= 1'b0;
      col_a_q <= '0;
      col_b_q <= '0;
      ctl_a_q <= '0;
      ctl_b_q <= '0;
    end else if (accept) begin
      full_q  <= 1'b1;
      ph_q    <= 1'b0;
      col_a_q <= in_col_a;
      col_b_q <= in_col_b;
      ctl_a_q <= in_ctl_a;
      ctl_b_q <= in_ctl_b;
    end else if (full_q && take) begin
      if (last_ph) full_q <= 1'b0;
      else         ph_q   <= 1'b1;
    end
  end

  assign cur_valid = full_q;
  assign cur_col   = ph_q ? col_b_q : col_a_q;
  assign cur_ctl   = ph_q ? ctl_b_q : ctl_a_q;

endmodule

// File: rtl/pixin_format.sv
module pixin_format
  import pixin_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic [1:0]        cfg_fmt,
  input  logic [3*CW-1:0]   col_in,
  output logic [3*CW-1:0]   col_out
);

  localparam int unsigned PAD = CW - F15_W;

  logic [CW-1:0]   r_in, g_in, b_in;
  logic [2*CW-1:0] pack16;

  assign r_in   = col_in[2*CW +: CW];
  assign g_in   = col_in[CW +: CW];
  assign b_in   = col_in[0 +: CW];
  assign pack16 = {g_in, b_in};

  always_comb begin
    unique case (cfg_fmt)
      FMT_RGB15: col_out = {pack16[2*F15_W +: F15_W], {PAD{1'b0}},
                            pack16[F15_W +: F15_W],   {PAD{1'b0}},
                            pack16[0 +: F15_W],       {PAD{1'b0}}};
      FMT_IDX8:  col_out = {r_in, r_in, r_in};
      default:   col_out = col_in;
    endcase
  end

endmodule

// File: rtl/pixin_outreg.sv
module pixin_outreg
  import pixin_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_valid,
  input  logic [3*CW-1:0]   src_col,
  input  pix_ctl_t          src_ctl,
  input  logic [PS_W-1:0]   cfg_sel_code,
  input  logic              cfg_kill_unsel,
  input  logic              cfg_sync_en,
  output logic              take,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3*CW-1:0]   out_col,
  output logic              out_sel,
  output logic              out_blank,
  output logic              out_sync,
  output logic              out_sync_dly
);

  logic [3*CW-1:0] col_n;
  logic            sel_n, zero_n;

  assign take   = !out_valid || out_ready;
  assign sel_n  = (src_ctl.ps == cfg_sel_code);
  assign zero_n = src_ctl.blank || (cfg_kill_unsel && !sel_n);

  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    assign col_n[ch*CW +: CW] = zero_n ? '0 : src_col[ch*CW +: CW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_col      <= '0;
      out_sel      <= 1'b0;
      out_blank    <= 1'b1;
      out_sync     <= 1'b0;
      out_sync_dly <= 1'b0;
    end else if (take) begin
      out_valid <= src_valid;
      if (src_valid) begin
        out_col      <= col_n;
        out_sel      <= sel_n;
        out_blank    <= src_ctl.blank;
        out_sync     <= src_ctl.sync && cfg_sync_en;
        out_sync_dly <= src_ctl.sync;
      end
    end
  end

endmodule

// File: rtl/pixin_pipe.sv
module pixin_pipe
  import pixin_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_mux2,
  input  logic [1:0]    cfg_fmt,
  input  logic [1:0]    cfg_sel_code,
  input  logic          cfg_kill_unsel,
  input  logic          cfg_sync_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_red_a,
  input  logic [CW-1:0] in_grn_a,
  input  logic [CW-1:0] in_blu_a,
  input  logic [CW-1:0] in_red_b,
  input  logic [CW-1:0] in_grn_b,
  input  logic [CW-1:0] in_blu_b,
  input  logic [1:0]    in_psel_a,
  input  logic [1:0]    in_psel_b,
  input  logic          in_blank_a,
  input  logic          in_blank_b,
  input  logic          in_sync_a,
  input  logic          in_sync_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_red,
  output logic [CW-1:0] out_grn,
  output logic [CW-1:0] out_blu,
  output logic          out_sel,
  output logic          out_blank,
  output logic          out_sync,
  output logic          out_sync_dly
);

  localparam int unsigned PIX_W = 3 * CW;

  pix_ctl_t          ctl_a, ctl_b, cur_ctl;
  logic [PIX_W-1:0]  cur_col, fmt_col, out_col;
  logic              cur_valid, take;

  assign ctl_a = '{ps: in_psel_a, blank: in_blank_a, sync: in_sync_a};
  assign ctl_b = '{ps: in_psel_b, blank: in_blank_b, sync: in_sync_b};

  pixin_capture #(.CW(CW)) u_cap (
    .clk(clk), .rst(rst), .cfg_mux2(cfg_mux2),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_col_a({in_red_a, in_grn_a, in_blu_a}),
    .in_col_b({in_red_b, in_grn_b, in_blu_b}),
    .in_ctl_a(ctl_a), .in_ctl_b(ctl_b),
    .take(take), .cur_valid(cur_valid), .cur_col(cur_col), .cur_ctl(cur_ctl)
  );

  pixin_format #(.CW(CW)) u_fmt (
    .cfg_fmt(cfg_fmt), .col_in(cur_col), .col_out(fmt_col)
  );

  pixin_outreg #(.CW(CW)) u_out (
    .clk(clk), .rst(rst),
    .src_valid(cur_valid), .src_col(fmt_col), .src_ctl(cur_ctl),
    .cfg_sel_code(cfg_sel_code), .cfg_kill_unsel(cfg_kill_unsel),
    .cfg_sync_en(cfg_sync_en), .take(take),
    .out_valid(out_valid), .out_ready(out_ready), .out_col(out_col),
    .out_sel(out_sel), .out_blank(out_blank), .out_sync(out_sync),
    .out_sync_dly(out_sync_dly)
  );

  assign out_red = out_col[2*CW +: CW];
  assign out_grn = out_col[CW +: CW];
  assign out_blu = out_col[0 +: CW];

endmodule

// File: rtl/pixin_pipe_chk.sv
module pixin_pipe_chk #(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    cfg_fmt,
  input logic          cfg_kill_unsel,
  input logic          cfg_sync_en,
  input logic          out_valid,
  input logic          out_ready,
  input logic [CW-1:0] out_red,
  input logic [CW-1:0] out_grn,
  input logic [CW-1:0] out_blu,
  input logic          out_sel,
  input logic          out_blank,
  input logic          out_sync,
  input logic          out_sync_dly
);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_blank));

  p_hold_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_red) && $stable(out_grn)
      && $stable(out_blu) && $stable(out_sel) && $stable(out_blank)
      && $stable(out_sync) && $stable(out_sync_dly)));

  p_index_equal_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cfg_fmt == 2'd2) |-> (out_red == out_grn && out_grn == out_blu));

  p_kill_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cfg_kill_unsel && !out_sel) |-> (out_red == '0 && out_grn == '0 && out_blu == '0));

  p_blank_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_blank) |-> (out_red == '0 && out_grn == '0 && out_blu == '0));

  p_sync_gate_r12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sync) |-> (cfg_sync_en && out_sync_dly));

endmodule

bind pixin_pipe pixin_pipe_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cfg_fmt(cfg_fmt), .cfg_kill_unsel(cfg_kill_unsel),
  .cfg_sync_en(cfg_sync_en), .out_valid(out_valid), .out_ready(out_ready),
  .out_red(out_red), .out_grn(out_grn), .out_blu(out_blu), .out_sel(out_sel),
  .out_blank(out_blank), .out_sync(out_sync), .out_sync_dly(out_sync_dly)
);

// File: tb/pixin_pipe_tb.sv
module pixin_pipe_tb;

  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          cfg_mux2 = 1'b0, cfg_kill_unsel = 1'b0, cfg_sync_en = 1'b0;
  logic [1:0]    cfg_fmt = 2'd0, cfg_sel_code = 2'd0;
  logic          in_valid = 1'b0, in_ready;
  logic [CW-1:0] in_red_a = '0, in_grn_a = '0, in_blu_a = '0;
  logic [CW-1:0] in_red_b = '0, in_grn_b = '0, in_blu_b = '0;
  logic [1:0]    in_psel_a = '0, in_psel_b = '0;
  logic          in_blank_a = 1'b0, in_blank_b = 1'b0, in_sync_a = 1'b0, in_sync_b = 1'b0;
  logic          out_valid, out_ready, out_sel, out_blank, out_sync, out_sync_dly;
  logic [CW-1:0] out_red, out_grn, out_blu;

  pixin_pipe #(.CW(CW)) u_dut (.*);

  typedef struct packed {
    logic [CW-1:0] r, g, b;
    logic sel, blank, sync, raw;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0, cyc = 0;
  int rdy_mode = 0;  // 0 always ready, 1 never, 2 uneven pattern

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t mk(input logic [CW-1:0] r, g, b, input logic [1:0] ps,
                              input logic bl, sy);
    exp_t e;
    logic [15:0] w;
    w = {g, b};
    case (cfg_fmt)
      2'd1: begin e.r = {w[14:10], 3'b0}; e.g = {w[9:5], 3'b0}; e.b = {w[4:0], 3'b0}; end
      2'd2: begin e.r = r; e.g = r; e.b = r; end
      default: begin e.r = r; e.g = g; e.b = b; end
    endcase
    e.sel = (ps == cfg_sel_code);
    if (bl || (cfg_kill_unsel && !e.sel)) begin e.r = '0; e.g = '0; e.b = '0; end
    e.blank = bl;
    e.sync = sy & cfg_sync_en;
    e.raw = sy;
    return e;
  endfunction

  // Output monitor: ready pattern and scoreboard, away from the active edge
  always @(negedge clk) begin
    cyc++;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = 1'b0;
      default: out_ready = (cyc % 3) != 0;
    endcase
    if (!rst && out_valid && out_ready) begin
      if (q.size() == 0) begin
        chk(1'b0, "R4 unexpected pixel", {out_red, out_grn, out_blu}, 0);
      end else begin
        exp_t e;
        string ctag;
        e = q.pop_front();
        if (e.blank) ctag = "R11 blank colour";
        else if (cfg_kill_unsel && !e.sel) ctag = "R10 kill colour";
        else if (cfg_fmt == 2'd1) ctag = "R7 15-bit colour";
        else if (cfg_fmt == 2'd2) ctag = "R8 index colour";
        else ctag = "R6 24-bit colour";
        ctag = {cfg_mux2 ? "R2 " : "R3 ", ctag};
        chk({out_red, out_grn, out_blu} == {e.r, e.g, e.b}, ctag,
            {out_red, out_grn, out_blu}, {e.r, e.g, e.b});
        chk(out_sel == e.sel, "R9 select flag", out_sel, e.sel);
        chk(out_blank == e.blank, "R11 blank flag", out_blank, e.blank);
        chk(out_sync == e.sync, "R12 gated sync", out_sync, e.sync);
        chk(out_sync_dly == e.raw, "R13 delayed sync", out_sync_dly, e.raw);
      end
    end
  end

  task automatic send_word(input int k, input int c);
    logic [CW-1:0] ra, ga, ba;
    ra = CW'(k * 53 + c * 7 + 1);
    ga = CW'(k * 29 + c * 11 + 64);
    ba = CW'(k * 91 + c * 3 + 5);
    forever begin
      @(negedge clk); #1;
      in_red_a = ra;          in_grn_a = ga;          in_blu_a = ba;
      in_red_b = ra ^ 8'hA5;  in_grn_b = CW'(ga + 17); in_blu_b = ~ba;
      in_psel_a = 2'(k);      in_psel_b = ~2'(k);
      in_blank_a = (k % 8 == 5); in_blank_b = (k % 8 == 2);
      in_sync_a = k[0];       in_sync_b = k[1];
      in_valid = 1'b1;
      if (in_ready) break;
    end
    q.push_back(mk(in_red_a, in_grn_a, in_blu_a, in_psel_a, in_blank_a, in_sync_a));
    if (cfg_mux2)
      q.push_back(mk(in_red_b, in_grn_b, in_blu_b, in_psel_b, in_blank_b, in_sync_b));
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((q.size() != 0 || out_valid) && n < 300) begin
      @(negedge clk); n++;
    end
    #1;
    chk(q.size() == 0 && !out_valid, "R4 all pixels delivered", q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R1 reset valid", out_valid, 0);
    chk(out_blank, "R1 reset blank", out_blank, 1);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); #1;
    chk(!out_valid && out_blank, "R1 after reset", {out_valid, out_blank}, 2'b01);
    chk(in_ready, "R1 ready after reset", in_ready, 1);

    // R13 latency: single-phase, always ready, sync on (k=1)
    rdy_mode = 0; cfg_mux2 = 1'b0; cfg_sync_en = 1'b1;
    send_word(1, 0);
    @(negedge clk); @(negedge clk); #1;
    chk(out_valid && out_sync_dly, "R13 sync two edges after input",
        {out_valid, out_sync_dly}, 2'b11);
    drain();

    // R5 stall in two-phase mode
    cfg_mux2 = 1'b1; rdy_mode = 1;
    send_word(3, 1);
    @(negedge clk); @(negedge clk); #1;
    chk(!in_ready, "R5 input stalled while B waits", in_ready, 0);
    chk(out_valid, "R4 pixel held under stall", out_valid, 1);
    rdy_mode = 2;
    drain();

    // Exhaustive configuration sweep
    for (int c = 0; c < 96; c++) begin
      cfg_mux2 = c[0];
      cfg_kill_unsel = c[1];
      cfg_sync_en = c[2];
      cfg_sel_code = 2'(c / 8);
      cfg_fmt = 2'((c / 32) % 3);
      rdy_mode = (c % 5 == 0) ? 0 : 2;
      for (int k = 0; k < 8; k++) send_word(k, c);
      drain();
    end

    // Unused format code behaves as 24-bit
    cfg_fmt = 2'd3; cfg_mux2 = 1'b1; cfg_kill_unsel = 1'b0;
    for (int k = 0; k < 4; k++) send_word(k, 200);
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule